// File: doc/BRIEF.md
# System Management Memory Strobe Steering

This block decides, for every processor bus cycle, whether the cycle goes to ordinary system memory or to the private memory used by the system management mode. It holds a small control register that is written through a configuration index port. Each cycle start presents the current processor mode (normal or management), the cycle kind (code fetch or data access) and the address. The block then drives exactly one of two address strobes: the main strobe or the management strobe.

The management memory window is given by a base and a size input. An address hits the window when base <= addr < base + size. A size of zero disables the window. Three control bits decide how a hit is routed. The first enables the management pins. The second opens the window from normal mode. The third sends management-mode data accesses inside the window to main memory. The block also qualifies the external active-low management interrupt pin into a request, and flags an illegal use of management-only instructions. It drives an output-enable for the management strobe, which floats while the pins are disabled.

Top module: `smm_steer`

## Requirements
- R1: After a synchronous reset, every control bit reads 0. Both strobes, the strobe output-enable, the interrupt request and the illegal-instruction flag are all 0.
- R2: A write with `cfg_idx` equal to 8'hC1 stores `cfg_wdata[4:0]` into the control register. The bit positions are: aux fill bit 0, pin enable bit 1, normal-window bit 2, main-window bit 3, lock-off bit 4. Bits 7:5 always read 0. A write to any other index leaves the register unchanged.
- R3: While pin enable is 0, the management strobe and its output-enable stay 0, the interrupt request stays 0, and every cycle uses the main strobe.
- R4: In normal mode with the normal-window bit 0 and the main-window bit 0, every cycle uses the main strobe.
- R5: In normal mode with pin enable and the normal-window bit set, a cycle inside the window uses the management strobe and a cycle outside it uses the main strobe. The interrupt pin is ignored in this state.
- R6: In management mode with the main-window bit 0, every cycle uses the management strobe.
- R7: In management mode with the main-window bit 1, a data access inside the window uses the main strobe. Any access outside the window uses the management strobe.
- R8: A code fetch inside the window in management mode uses the management strobe, whatever the main-window bit holds.
- R9: When the normal-window and main-window bits are both 1, the main-window bit wins. In normal mode a data access inside the window uses the main strobe, and a code fetch inside the window uses the management strobe.
- R10: The window holds base <= addr < base + size and nothing else. A size of zero matches no address.
- R11: A valid cycle asserts exactly one strobe, for one clock, one clock after the cycle is presented. With no valid cycle, neither strobe is asserted.
- R12: The illegal-instruction flag rises one clock after a management-only instruction is presented while pin enable is 0, or while in normal mode with the normal-window bit 0.
- R13: The interrupt request is 1 one clock after the pin is sampled low, but only when pin enable is 1 and the pin is not ignored under R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current control register contents |
| rgn_base | input | ADDR_W | Window base address |
| rgn_size | input | ADDR_W | Window size, 0 disables the window |
| cyc_valid | input | 1 | A bus cycle starts this clock |
| cyc_code | input | 1 | 1 = code fetch, 0 = data access |
| cyc_addr | input | ADDR_W | Cycle address |
| in_smm | input | 1 | Processor is in management mode |
| smi_pin_n | input | 1 | External management interrupt, active low |
| sm_insn | input | 1 | A management-only instruction is being executed |
| main_stb | output | 1 | Strobe for main memory |
| sm_stb | output | 1 | Strobe for management memory |
| sm_stb_oe | output | 1 | Output-enable for the management strobe |
| smi_req | output | 1 | Qualified management interrupt request |
| bad_op | output | 1 | Illegal management instruction flag |

## Verification
All routing, request and flag outputs are registered. Each one reflects the inputs and the control value present at the clock edge one clock earlier. A configuration write changes `cfg_rdata` right after its edge, but changes routing only for cycles presented after that edge. The bench drives stimulus on the falling edge and compares every output on the following falling edge. The expected values come from a behavioural model that updates its own copy of the control register only after it has computed that cycle's prediction. That matches the one-clock latency of both paths. The window-edge addresses and the zero-size case are placed around each mode change.

// File: rtl/smm_steer_pkg.sv
package smm_steer_pkg;
  typedef struct packed {
    logic [2:0] rsvd;
    logic       lock_off;
    logic       main_win;
    logic       nrm_win;
    logic       pin_en;
    logic       aux_fill;
  } smm_ctl_t;
endpackage

// File: rtl/smm_ctl_reg.sv
module smm_ctl_reg
  import smm_steer_pkg::*;
#(
  parameter logic [7:0] CTL_IDX = 8'hC1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output smm_ctl_t   ctl
);
  logic hit_idx;
  assign hit_idx = we && (idx == CTL_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (hit_idx) begin
      ctl.aux_fill <= wdata[0];
      ctl.pin_en   <= wdata[1];
      ctl.nrm_win  <= wdata[2];
      ctl.main_win <= wdata[3];
      ctl.lock_off <= wdata[4];
      ctl.rsvd     <= '0;
    end
  end

  // R2: writes to other indices leave the register alone
  p_other_idx_r2: assert property (@(posedge clk) disable iff (rst)
    (we && idx != CTL_IDX) |=> $stable(ctl));
endmodule

// File: rtl/smm_rgn_match.sv
module smm_rgn_match #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int EXT_W = ADDR_W + 1;
  logic [EXT_W-1:0] offs;

  always_comb begin
    offs = {1'b0, addr} - {1'b0, base};
    hit  = (size != '0) && (addr >= base) && (offs < {1'b0, size});
  end
endmodule

// File: rtl/smm_route.sv
module smm_route
  import smm_steer_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  smm_ctl_t ctl,
  input  logic     cyc_valid,
  input  logic     cyc_code,
  input  logic     rgn_hit,
  input  logic     in_smm,
  input  logic     smi_pin_n,
  input  logic     sm_insn,
  output logic     main_stb,
  output logic     sm_stb,
  output logic     sm_stb_oe,
  output logic     smi_req,
  output logic     bad_op
);
  logic to_sm, main_data_hit, pin_ignored;

  always_comb begin
    main_data_hit = ctl.main_win && !cyc_code && rgn_hit;
    if (!ctl.pin_en)
      to_sm = 1'b0;
    else if (in_smm)
      to_sm = !main_data_hit;
    else
      to_sm = ctl.nrm_win && rgn_hit && !main_data_hit;
    pin_ignored = !in_smm && ctl.nrm_win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_stb  <= 1'b0;
      sm_stb    <= 1'b0;
      sm_stb_oe <= 1'b0;
      smi_req   <= 1'b0;
      bad_op    <= 1'b0;
    end else begin
      main_stb  <= cyc_valid && !to_sm;
      sm_stb    <= cyc_valid && to_sm;
      sm_stb_oe <= ctl.pin_en;
      smi_req   <= ctl.pin_en && !smi_pin_n && !pin_ignored;
      bad_op    <= sm_insn && (!ctl.pin_en || (!in_smm && !ctl.nrm_win));
    end
  end

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |=> $countones({main_stb, sm_stb}) == 1);
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !cyc_valid |=> !main_stb && !sm_stb);
  p_float_r3: assert property (@(posedge clk) disable iff (rst)
    !ctl.pin_en |=> !sm_stb && !sm_stb_oe && !smi_req);
  p_code_smm_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_code && in_smm && ctl.pin_en) |=> sm_stb);
  p_pin_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (!in_smm && ctl.nrm_win) |=> !smi_req);
endmodule

// File: rtl/smm_steer.sv
module smm_steer
  import smm_steer_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [7:0]  CTL_IDX = 8'hC1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] rgn_base,
  input  logic [ADDR_W-1:0] rgn_size,
  input  logic              cyc_valid,
  input  logic              cyc_code,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              in_smm,
  input  logic              smi_pin_n,
  input  logic              sm_insn,
  output logic              main_stb,
  output logic              sm_stb,
  output logic              sm_stb_oe,
  output logic              smi_req,
  output logic              bad_op
);
  smm_ctl_t ctl;
  logic     rgn_hit;

  smm_ctl_reg #(.CTL_IDX(CTL_IDX)) u_ctl (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata), .ctl(ctl)
  );

  smm_rgn_match #(.ADDR_W(ADDR_W)) u_rgn (
    .base(rgn_base), .size(rgn_size), .addr(cyc_addr), .hit(rgn_hit)
  );

  smm_route u_route (
    .clk(clk), .rst(rst), .ctl(ctl), .cyc_valid(cyc_valid), .cyc_code(cyc_code),
    .rgn_hit(rgn_hit), .in_smm(in_smm), .smi_pin_n(smi_pin_n), .sm_insn(sm_insn),
    .main_stb(main_stb), .sm_stb(sm_stb), .sm_stb_oe(sm_stb_oe),
    .smi_req(smi_req), .bad_op(bad_op)
  );

  assign cfg_rdata = ctl;
endmodule

// File: tb/smm_steer_tb.sv
module smm_steer_tb;
  localparam int AW = 16;
  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [7:0] cfg_idx = 0, cfg_wdata = 0, cfg_rdata;
  logic [AW-1:0] rgn_base = 16'h4000, rgn_size = 16'h0100, cyc_addr = 0;
  logic cyc_valid = 0, cyc_code = 0, in_smm = 0, smi_pin_n = 1, sm_insn = 0;
  logic main_stb, sm_stb, sm_stb_oe, smi_req, bad_op;
  int total = 0, bad = 0, cyc = 0;
  logic [7:0] m_ctl = 0;
  logic e_main = 0, e_sm = 0, e_oe = 0, e_smi = 0, e_bad = 0;
  string e_tag = "R1";

  always #5 clk = ~clk;

  smm_steer #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rgn_base(rgn_base), .rgn_size(rgn_size),
    .cyc_valid(cyc_valid), .cyc_code(cyc_code), .cyc_addr(cyc_addr), .in_smm(in_smm),
    .smi_pin_n(smi_pin_n), .sm_insn(sm_insn), .main_stb(main_stb), .sm_stb(sm_stb),
    .sm_stb_oe(sm_stb_oe), .smi_req(smi_req), .bad_op(bad_op)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: compare the previous prediction, apply new stimulus, predict
  task automatic step(logic we, logic [7:0] idx, logic [7:0] wd, logic v, logic code,
                      int addr, logic smm, logic pin_n, logic insn, string tag);
    logic pin, nw, mw, hit, sm;
    chk(e_tag, "main_stb R11", main_stb, e_main);
    chk(e_tag, "sm_stb R11", sm_stb, e_sm);
    chk("R3", "sm_stb_oe", sm_stb_oe, e_oe);
    chk("R13", "smi_req", smi_req, e_smi);
    chk("R12", "bad_op", bad_op, e_bad);
    chk("R2", "cfg_rdata", cfg_rdata, m_ctl);
    cfg_we = we; cfg_idx = idx; cfg_wdata = wd; cyc_valid = v; cyc_code = code;
    cyc_addr = addr[AW-1:0]; in_smm = smm; smi_pin_n = pin_n; sm_insn = insn;
    pin = m_ctl[1]; nw = m_ctl[2]; mw = m_ctl[3];
    hit = (rgn_size != 0) && (addr >= int'(rgn_base)) && (addr < int'(rgn_base) + int'(rgn_size));
    if (!pin) sm = 0;
    else if (smm) sm = !(mw && !code && hit);
    else sm = nw && hit && !(mw && !code);
    e_main = v && !sm; e_sm = v && sm; e_oe = pin;
    e_smi = pin && !pin_n && !(!smm && nw);
    e_bad = insn && (!pin || (!smm && !nw));
    e_tag = tag;
    if (we && idx == 8'hC1) m_ctl = {3'b000, wd[4:0]};
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] idx, logic [7:0] wd);
    step(1, idx, wd, 0, 0, 0, 0, 1, 0, "R2");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "main_stb", main_stb, 0);
    chk("R1", "sm_stb", sm_stb, 0);
    chk("R1", "sm_stb_oe", sm_stb_oe, 0);
    chk("R1", "smi_req", smi_req, 0);
    chk("R1", "bad_op", bad_op, 0);
    chk("R1", "cfg_rdata", cfg_rdata, 0);
    rst = 0;
    // R3: pins disabled
    step(0,0,0, 1,0,'h4010, 0,0,1, "R3");
    step(0,0,0, 1,1,'h4010, 1,0,1, "R3");
    wr(8'hC1, 8'h02);
    // R4: pins on, no window from normal mode
    step(0,0,0, 1,0,'h4010, 0,0,1, "R4");
    step(0,0,0, 1,1,'h1000, 0,1,0, "R4");
    wr(8'hC1, 8'h06);
    // R5 and R10: window open from normal mode, edges
    step(0,0,0, 1,0,'h4010, 0,0,1, "R5");
    step(0,0,0, 1,0,'h3FFF, 0,0,0, "R10");
    step(0,0,0, 1,0,'h4000, 0,1,0, "R10");
    step(0,0,0, 1,1,'h40FF, 0,1,0, "R10");
    step(0,0,0, 1,0,'h4100, 0,1,0, "R10");
    rgn_size = 0;
    step(0,0,0, 1,0,'h4000, 0,1,0, "R10");
    rgn_size = 16'h0100;
    wr(8'hC1, 8'h02);
    // R6: management mode, all to management memory
    step(0,0,0, 1,0,'h1234, 1,0,1, "R6");
    step(0,0,0, 1,0,'h4020, 1,1,0, "R6");
    wr(8'hC1, 8'h0A);
    // R7 and R8
    step(0,0,0, 1,0,'h4020, 1,1,0, "R7");
    step(0,0,0, 1,0,'h5000, 1,1,0, "R7");
    step(0,0,0, 1,1,'h4020, 1,1,0, "R8");
    step(0,0,0, 1,1,'h5000, 1,0,0, "R8");
    wr(8'hC1, 8'h0E);
    // R9: both window bits in normal mode
    step(0,0,0, 1,0,'h4020, 0,1,0, "R9");
    step(0,0,0, 1,1,'h4020, 0,0,1, "R9");
    step(0,0,0, 1,0,'h6000, 0,1,0, "R9");
    // R2: reserved bits, foreign index
    wr(8'hC1, 8'hFF);
    wr(8'hC0, 8'h00);
    wr(8'h41, 8'h00);
    // R13 with management mode and pin low
    step(0,0,0, 0,0,0, 1,0,0, "R13");
    // R11: idle cycles
    for (int i = 0; i < 4; i++) step(0,0,0, 0,0,'h4000, i[0],1,0, "R11");
    step(0,0,0, 0,0,0, 0,1,0, "R11");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule